// File: doc/BRIEF.md
# Isochronous Cycle Timer Event Monitor

This block keeps a local isochronous cycle timer and produces the cycle-related interrupt event strobes of a serial-bus link layer. The timer has three fields: a 7-bit seconds count, a 13-bit cycle count and a 12-bit offset. The offset advances on a timer clock enable of nominally 24.576 MHz. The block watches cycle-start traffic and gap indications from the link. From them it raises one-cycle pulses for these events:

- a new cycle
- a seconds-bit-6 change (once every 64 seconds)
- a received cycle start whose time disagrees with the local timer
- a lost cycle, either seen or predicted
- an over-long cycle while this node is cycle master

When the node is not cycle master, a received cycle start also sets the local seconds and count fields to the received values. When it is cycle master, a watchdog times each cycle it starts. If the subaction gap does not end within 3072 timer ticks, the block raises a request to leave cycle-master mode.

Top module: `cycle_timer_monitor`

## Requirements
- R1: `timer_o` is {seconds[31:25], count[24:12], offset[11:0]}. On each cycle with `tick_i` high the offset steps up by one and wraps from 3071 to 0. On that wrap the count steps up and wraps from 7999 to 0, and on the count wrap the seconds step up modulo 128.
- R2: `synch_o` is high for exactly one cycle directly after any clock edge that changes bit 0 of the count, whether by counting or by loading.
- R3: `sec64_o` is high for exactly one cycle directly after any clock edge that changes bit 6 of the seconds.
- R4: A `cs_rx_i` strobe raises `inconsistent_o` one cycle later when `cs_rx_sec_i` or `cs_rx_cnt_i` differs from the timer's seconds or count at that time. When both match, `inconsistent_o` stays low.
- R5: With `cyc_master_i` low, a `cs_rx_i` strobe loads the received seconds and count into the timer after the comparison; the offset is kept. With `cyc_master_i` high, the timer is not loaded.
- R6: A window runs from one cycle-synch event to the next. If no `cs_rx_i` or `cs_sent_i` strobe falls in a window, `lost_o` pulses one cycle after the synch event that closes it. A strobe that coincides with a synch event counts toward the window that event opens. The first synch event after reset raises no lost event.
- R7: Within a window that has had no cycle start, an `arb_gap_i` strobe raises `lost_o` one cycle later as a prediction.
- R8: Within a window that has had no cycle start, a second `sub_gap_i` after the first raises `lost_o` one cycle later as a prediction. A cycle start between the two gaps prevents it.
- R9: At most one lost event is reported per window. After a prediction, the synch event that closes the window raises no further `lost_o`.
- R10: With `cyc_master_i` high, `cs_sent_i` starts a watchdog that counts `tick_i` cycles. If 3072 ticks pass before a `sub_gap_i`, `too_long_o` and `master_clr_o` pulse together for one cycle. A `sub_gap_i` after 3071 ticks raises no event. With `cyc_master_i` low, the watchdog does not run.
- R11: After reset, `timer_o` is zero and every event output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable |
| cs_rx_i | input | 1 | Cycle start received, one-cycle strobe |
| cs_rx_sec_i | input | 7 | Seconds field of the received cycle start |
| cs_rx_cnt_i | input | 13 | Count field of the received cycle start |
| cs_sent_i | input | 1 | Cycle start being sent, one-cycle strobe |
| sub_gap_i | input | 1 | Subaction gap detected, one-cycle strobe |
| arb_gap_i | input | 1 | Arbitration reset gap detected, one-cycle strobe |
| cyc_master_i | input | 1 | Node is acting as cycle master |
| timer_o | output | 32 | Current cycle timer word |
| synch_o | output | 1 | New-cycle event pulse |
| sec64_o | output | 1 | Seconds bit 6 change pulse |
| inconsistent_o | output | 1 | Received cycle start disagrees with the timer |
| lost_o | output | 1 | Cycle lost, seen or predicted |
| too_long_o | output | 1 | Cycle-master cycle exceeded its limit |
| master_clr_o | output | 1 | Request to clear cycle-master mode |

## Verification
The lost-cycle logic is driven with these window patterns:
- a window with no traffic
- a window that contains a sent start
- a lone arbitration reset gap
- two subaction gaps in a row
- two subaction gaps with a start between them

Together these separate an actual loss from each kind of prediction, and show that a prediction blocks the later actual report. The comparison is tried with a matching cycle start and with a mismatching one. Loads are made with and without cycle-master mode. One load sets the timer just below a seconds-bit-6 change, so the next count wrap crosses it. The watchdog is run to 3071 ticks before a gap and to exactly 3072 ticks; a long gapless run outside master mode shows that the watchdog does not run there.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  parameter int SEC_W = 7;
  parameter int CNT_W = 13;
  parameter int OFF_W = 12;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CNT_W-1:0] cnt;
    logic [OFF_W-1:0] off;
  } cyc_time_t;
endpackage

// File: rtl/cyc_timer_core.sv
module cyc_timer_core
  import cyc_timer_pkg::*;
#(
  parameter int OFF_MAX = 3072,
  parameter int CNT_MAX = 8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_sec_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  output cyc_time_t        time_o,
  output logic             synch_o,
  output logic             sec64_o
);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_MAX - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MAX - 1);

  cyc_time_t t_q;
  logic      lsb_d_q, msb_d_q;
  logic      off_wrap;

  assign off_wrap = tick_i && (t_q.off == OFF_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q     <= '0;
      lsb_d_q <= 1'b0;
      msb_d_q <= 1'b0;
    end else begin
      lsb_d_q <= t_q.cnt[0];
      msb_d_q <= t_q.sec[SEC_W-1];
      if (tick_i) t_q.off <= off_wrap ? '0 : t_q.off + 1'b1;
      // load wins over a carry in the same cycle
      if (load_i) begin
        t_q.sec <= load_sec_i;
        t_q.cnt <= load_cnt_i;
      end else if (off_wrap) begin
        if (t_q.cnt == CNT_LAST) begin
          t_q.cnt <= '0;
          t_q.sec <= t_q.sec + 1'b1;
        end else begin
          t_q.cnt <= t_q.cnt + 1'b1;
        end
      end
    end
  end

  assign time_o  = t_q;
  assign synch_o = t_q.cnt[0] ^ lsb_d_q;
  assign sec64_o = t_q.sec[SEC_W-1] ^ msb_d_q;

  AST_OFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_q.off <= OFF_LAST); // R1
  AST_OFF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (t_q.off == (($past(t_q.off) == OFF_LAST) ? '0 : $past(t_q.off) + 1'b1))); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(t_q)); // R1
endmodule

// File: rtl/cyc_lost_tracker.sv
module cyc_lost_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic synch_i,
  input  logic cs_i,
  input  logic sub_gap_i,
  input  logic arb_gap_i,
  output logic lost_o
);
  logic armed_q, seen_cs_q, gap_q, pred_q, lost_q;
  logic can_pred;

  assign can_pred = armed_q && !seen_cs_q && !pred_q && !cs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      seen_cs_q <= 1'b0;
      gap_q     <= 1'b0;
      pred_q    <= 1'b0;
      lost_q    <= 1'b0;
    end else begin
      lost_q <= 1'b0;
      if (synch_i) begin
        lost_q    <= armed_q && !seen_cs_q && !pred_q;
        armed_q   <= 1'b1;
        seen_cs_q <= cs_i;
        gap_q     <= 1'b0;
        pred_q    <= 1'b0;
      end else begin
        if (cs_i) seen_cs_q <= 1'b1;
        if (can_pred) begin
          if (arb_gap_i || (sub_gap_i && gap_q)) begin
            lost_q <= 1'b1;
            pred_q <= 1'b1;
          end else if (sub_gap_i) begin
            gap_q <= 1'b1;
          end
        end
      end
    end
  end

  assign lost_o = lost_q;

  AST_LOST_NEEDS_SYNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> armed_q); // R6
  AST_PRED_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_q && synch_i) |=> !lost_o); // R9
endmodule

// File: rtl/cyc_master_watchdog.sv
module cyc_master_watchdog #(
  parameter int LIMIT = 3072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cyc_master_i,
  input  logic cs_sent_i,
  input  logic sub_gap_i,
  output logic too_long_o,
  output logic master_clr_o
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(LIMIT - 1);

  logic          run_q, fire_q;
  logic [TW-1:0] ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      fire_q  <= 1'b0;
      ticks_q <= '0;
    end else if (!cyc_master_i) begin
      run_q   <= 1'b0;
      fire_q  <= 1'b0;
      ticks_q <= '0;
    end else begin
      fire_q <= 1'b0;
      if (cs_sent_i) begin
        run_q   <= 1'b1;
        ticks_q <= '0;
      end else if (run_q) begin
        if (sub_gap_i) begin
          run_q <= 1'b0;
        end else if (tick_i) begin
          if (ticks_q == T_LAST) begin
            run_q  <= 1'b0;
            fire_q <= 1'b1;
          end else begin
            ticks_q <= ticks_q + 1'b1;
          end
        end
      end
    end
  end

  assign too_long_o   = fire_q;
  assign master_clr_o = fire_q;

  AST_FIRE_IN_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    too_long_o |-> $past(cyc_master_i)); // R10
  AST_TICKS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ticks_q <= T_LAST); // R10
  AST_FIRE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    too_long_o |=> !too_long_o); // R10
endmodule

// File: rtl/cycle_timer_monitor.sv
module cycle_timer_monitor
  import cyc_timer_pkg::*;
#(
  parameter int OFF_MAX = 3072,
  parameter int CNT_MAX = 8000,
  parameter int LIMIT   = 3072
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cs_rx_i,
  input  logic [SEC_W-1:0] cs_rx_sec_i,
  input  logic [CNT_W-1:0] cs_rx_cnt_i,
  input  logic             cs_sent_i,
  input  logic             sub_gap_i,
  input  logic             arb_gap_i,
  input  logic             cyc_master_i,
  output logic [31:0]      timer_o,
  output logic             synch_o,
  output logic             sec64_o,
  output logic             inconsistent_o,
  output logic             lost_o,
  output logic             too_long_o,
  output logic             master_clr_o
);
  cyc_time_t now;
  logic      synch, incons_q, mismatch;

  cyc_timer_core #(.OFF_MAX(OFF_MAX), .CNT_MAX(CNT_MAX)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (cs_rx_i && !cyc_master_i),
    .load_sec_i (cs_rx_sec_i),
    .load_cnt_i (cs_rx_cnt_i),
    .time_o     (now),
    .synch_o    (synch),
    .sec64_o    (sec64_o)
  );

  assign mismatch = (cs_rx_sec_i != now.sec) || (cs_rx_cnt_i != now.cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) incons_q <= 1'b0;
    else         incons_q <= cs_rx_i && mismatch;
  end

  cyc_lost_tracker u_lost (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .synch_i   (synch),
    .cs_i      (cs_rx_i || cs_sent_i),
    .sub_gap_i (sub_gap_i),
    .arb_gap_i (arb_gap_i),
    .lost_o    (lost_o)
  );

  cyc_master_watchdog #(.LIMIT(LIMIT)) u_wdog (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .cyc_master_i (cyc_master_i),
    .cs_sent_i    (cs_sent_i),
    .sub_gap_i    (sub_gap_i),
    .too_long_o   (too_long_o),
    .master_clr_o (master_clr_o)
  );

  assign timer_o        = now;
  assign synch_o        = synch;
  assign inconsistent_o = incons_q;

  AST_INCONS_AFTER_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inconsistent_o |-> $past(cs_rx_i)); // R4
  AST_MASTER_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_master_i && cs_rx_i && !tick_i) |=> $stable(timer_o)); // R5
endmodule

// File: tb/cycle_timer_monitor_tb.sv
module cycle_timer_monitor_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 0, cs_rx_i = 0, cs_sent_i = 0, sub_gap_i = 0, arb_gap_i = 0;
  logic        cyc_master_i = 0;
  logic [6:0]  cs_rx_sec_i = '0;
  logic [12:0] cs_rx_cnt_i = '0;
  logic [31:0] timer_o;
  logic        synch_o, sec64_o, inconsistent_o, lost_o, too_long_o, master_clr_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_v[$];  // {too_long, lost, incons, sec64, synch}
  string      exp_t[$];

  always #2.5 clk_i = ~clk_i;

  cycle_timer_monitor u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [4:0] v, input string tag);
    exp_v.push_back(v);
    exp_t.push_back(tag);
  endtask

  task automatic drive(input logic tk, input logic rx, input logic [6:0] s, input logic [12:0] c,
                       input logic sent, input logic sg, input logic ag);
    @(posedge clk_i); #1;
    tick_i = tk; cs_rx_i = rx; cs_rx_sec_i = s; cs_rx_cnt_i = c;
    cs_sent_i = sent; sub_gap_i = sg; arb_gap_i = ag;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic chk_time(input logic [6:0] s, input logic [12:0] c, input logic [11:0] o, input string tag);
    @(negedge clk_i);
    chk(timer_o == {s, c, o}, tag, timer_o, {s, c, o});
  endtask

  // monitor: every event pulse must match the next scoreboard entry
  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [4:0] v;
      v = {too_long_o, lost_o, inconsistent_o, sec64_o, synch_o};
      if (too_long_o || master_clr_o)
        chk(master_clr_o == too_long_o, "R10 clear", 32'(master_clr_o), 32'(too_long_o));
      if (v != '0) begin
        if (exp_v.size() == 0) begin
          chk(1'b0, "unexpected event R2/R3/R4/R6/R9/R10", 32'(v), 32'h0);
        end else begin
          logic [4:0] e;
          string t;
          e = exp_v.pop_front();
          t = exp_t.pop_front();
          chk(v == e, t, 32'(v), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog timeout", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(timer_o == 0 && {synch_o, sec64_o, inconsistent_o, lost_o, too_long_o, master_clr_o} == 0,
        "R11 reset", timer_o, 32'h0);

    // mismatch + load
    expect_ev(5'b00100, "R4 mismatch");
    drive(0, 1, 7'd5, 13'd10, 0, 0, 0); idle();
    chk_time(7'd5, 13'd10, 12'd0, "R5 load");
    // matching start: no event
    drive(0, 1, 7'd5, 13'd10, 0, 0, 0); idle();
    @(negedge clk_i);
    chk(inconsistent_o == 0, "R4 match", 32'(inconsistent_o), 32'h0);
    // first synch, no lost
    expect_ev(5'b00001, "R2 first synch");
    ticks(3072); idle();
    chk_time(7'd5, 13'd11, 12'd0, "R1 count step");
    // empty window -> actual lost
    expect_ev(5'b00001, "R2 synch");
    expect_ev(5'b01000, "R6 actual lost");
    ticks(3072); idle();
    // sent start saves the window; not master so no watchdog
    drive(0, 0, 0, 0, 1, 0, 0); idle();
    expect_ev(5'b00001, "R6 window with start");
    ticks(3072); idle();
    // arbitration gap prediction, then no second lost
    expect_ev(5'b01000, "R7 arb gap predict");
    drive(0, 0, 0, 0, 0, 0, 1); idle();
    expect_ev(5'b00001, "R9 no repeat after arb predict");
    ticks(3072); idle();
    // two subaction gaps prediction
    expect_ev(5'b01000, "R8 two gaps predict");
    drive(0, 0, 0, 0, 0, 1, 0); idle();
    drive(0, 0, 0, 0, 0, 1, 0); idle();
    expect_ev(5'b00001, "R9 no repeat after gap predict");
    ticks(3072); idle();
    // gap, start, gap: no prediction
    drive(0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 0); idle();
    expect_ev(5'b00001, "R8 start between gaps");
    ticks(3072); idle();
    chk_time(7'd5, 13'd16, 12'd0, "R1 after windows");
    // load near the 64-second boundary
    expect_ev(5'b00101, "R5 load mismatch+synch");
    drive(0, 1, 7'd63, 13'd7999, 0, 0, 0); idle();
    drive(0, 0, 0, 0, 1, 0, 0); idle();
    expect_ev(5'b00011, "R3 sec64 at count wrap");
    ticks(3072); idle();
    chk_time(7'd64, 13'd0, 12'd0, "R1 count wrap");
    // master mode: compare but no load
    drive(0, 0, 0, 0, 0, 0, 0); cyc_master_i = 1'b1;
    expect_ev(5'b00100, "R4 mismatch in master");
    drive(0, 1, 7'd1, 13'd1, 0, 0, 0); idle();
    chk_time(7'd64, 13'd0, 12'd0, "R5 master no load");
    // watchdog: gap after 3071 ticks is in time
    drive(0, 0, 0, 0, 1, 0, 0);
    ticks(3071);
    drive(0, 0, 0, 0, 0, 1, 0); idle();
    chk_time(7'd64, 13'd0, 12'd3071, "R10 gap in time");
    // watchdog: 3072 ticks without gap
    expect_ev(5'b00001, "R2 synch during watchdog");
    expect_ev(5'b10000, "R10 too long");
    drive(0, 0, 0, 0, 1, 0, 0);
    ticks(3072); idle();
    repeat (4) idle();
    cyc_master_i = 1'b0;
    repeat (4) idle();
    @(negedge clk_i);
    chk(exp_v.size() == 0, "R9 pending events", 32'(exp_v.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule